// File: doc/BRIEF.md
# TPM FIFO Register Interface Controller

This block is the device-side register file and command state machine for a single-locality TPM interface that uses the FIFO register model. A transaction front end opens each register access with a start pulse that carries a 24-bit address and a direction. It then moves data one byte per cycle, either write bytes or read-byte requests, and closes the access with an end pulse. The block holds the locality-access register, the status register and a 64-byte buffer. That buffer holds the command the host sends and, later, the response the host reads back.

The host first asks for the command path by writing the command-ready bit. It then streams the command into the data FIFO address. The block reads the big-endian length from header bytes 2 to 5 and uses it to decide whether it still expects more data. When the host writes the go bit with nothing left to receive, the block raises a one-cycle execute request. The execution agent takes the command from a flat buffer output and answers with a parallel response. The block loads that response into the buffer and flags it as available for reading.

Top module: `tpm_fifo_regs`

## Requirements
- R1: After reset the status register (address 0x018) reads 0x04004080, meaning family 1 in bits 27:26, burst count 64 in bits 23:8 and the valid flag in bit 7. The access register (address 0x000) reads 0x80. The controller is idle with an empty buffer.
- R2: Address 0x014 reads 0x30000615, address 0xF04 reads the revision parameter (0), and address 0xF00 reads {device id, vendor id}. Register bytes are returned least significant first, and at most 4 of them carry `rd_vld`. An address with no readable register returns `rd_data` 0 with `rd_vld` low.
- R3: A write to the status or access register acts only when its value equals one command bit. That value is the first four bytes of the status write, least significant first, or the first byte of the access write. Zero, several bits at once, or any other bit leaves every register unchanged.
- R4: Writing status bit 6 (command ready) moves idle to ready and sets bit 6, and keeps bit 6 set in ready. In receiving, executing or completing it moves to idle and clears bit 6.
- R5: Writing access bit 1 sets access bit 5. Writing access bit 5 clears it and forces idle from any state.
- R6: Writing status bit 5 (go) in receiving with status bit 3 (expect) clear moves to executing and pulses `exec_req` for exactly one cycle. In any other state, or while expect is set, go does nothing.
- R7: A write burst to address 0x024 is accepted in receiving, or in ready with an empty buffer (which enters receiving). Its bytes are appended to `cmd_data` from byte 0 upward. A burst that starts in any other state is discarded.
- R8: An accepted burst that would take the write index past 64 is dropped whole: the index returns to 0 and the state returns to ready.
- R9: At the end of each accepted burst, status bit 3 is set if fewer than 6 bytes are held or the index is below the big-endian length in bytes 2 to 5, and cleared otherwise. `cmd_len` shows the write index.
- R10: A read burst at 0x024 returns bytes from the read index while it is below the write index, and one byte per request. Past that point `rd_vld` stays low. When the burst ends with the indices equal, status bits 4 and 6 are cleared.
- R11: In executing, a response of 1 to 64 bytes loads the buffer, sets the read index to 0 and the write index to its length, sets status bit 4 (data available) and moves to completing. A response of length 0 or above 64 is dropped.
- R12: Writing status bit 1 in completing rewinds the read index to 0 so the response can be read again. Writing status bit 24 (cancel) changes nothing.
- R13: Every entry into idle empties the buffer, so `cmd_len` reads 0 and a FIFO read returns no valid byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Opens an access; captures address and direction |
| tx_addr | input | 24 | Register address of the access |
| tx_write | input | 1 | 1 for write access, 0 for read |
| tx_wvld | input | 1 | Write byte present this cycle |
| tx_wdata | input | 8 | Write byte |
| tx_rreq | input | 1 | Request for the next read byte |
| tx_end | input | 1 | Closes the access and commits register writes |
| rd_data | output | 8 | Read byte, valid the cycle after the request |
| rd_vld | output | 1 | Read byte carries register or buffer content |
| exec_req | output | 1 | One-cycle request to execute the held command |
| cmd_len | output | 7 | Current write index (bytes held) |
| cmd_data | output | 512 | Buffer contents, byte 0 in bits 7:0 |
| rsp_vld | input | 1 | Response offered by the execution agent |
| rsp_len | input | 8 | Response length in bytes |
| rsp_data | input | 512 | Response bytes, byte 0 in bits 7:0 |

## Verification
The hardest states to reach are the completing state with a partly read response, where rewinding and the final read clear the status flags, and a receive overflow that lands in the middle of a command. The stimulus reaches both by running full lifecycles: it requests, streams a header whose length covers two bursts, issues go, rejects malformed responses, then loads a real one. After that it reads the response in two uneven bursts and rewinds it. Overflow is provoked with a 40-byte burst followed by a 30-byte one. A later 6-byte command is then accepted, which shows the state really fell back to ready.

// File: rtl/tpm_fifo_regs.sv
module tpm_fifo_regs #(
  parameter int          ADDR_W    = 24,
  parameter int          BUF_BYTES = 64,
  parameter logic [15:0] VEN_ID    = 16'h1F3C,
  parameter logic [15:0] DEV_ID    = 16'h0A11,
  parameter logic [31:0] REV_ID    = 32'h0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               tx_start,
  input  logic [ADDR_W-1:0]                  tx_addr,
  input  logic                               tx_write,
  input  logic                               tx_wvld,
  input  logic [7:0]                         tx_wdata,
  input  logic                               tx_rreq,
  input  logic                               tx_end,
  output logic [7:0]                         rd_data,
  output logic                               rd_vld,
  output logic                               exec_req,
  output logic [$clog2(BUF_BYTES+1)-1:0]     cmd_len,
  output logic [BUF_BYTES*8-1:0]             cmd_data,
  input  logic                               rsp_vld,
  input  logic [$clog2(BUF_BYTES+1):0]       rsp_len,
  input  logic [BUF_BYTES*8-1:0]             rsp_data
);
  localparam int IDX_W = $clog2(BUF_BYTES + 1);
  localparam int AW    = $clog2(BUF_BYTES);
  localparam int CNT_W = IDX_W + 1;
  localparam int POS_W = CNT_W + 1;
  localparam int LEN_W = IDX_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_READY, S_RECV, S_EXEC, S_DONE} st_t;
  typedef enum logic [2:0] {SEL_NONE, SEL_ACC, SEL_STS, SEL_FIFO, SEL_CAP, SEL_DID, SEL_RID} sel_t;

  st_t              st;
  sel_t             sel, sel_d;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             cr, da, expct, active;
  logic             in_tx, tx_w, fifo_ok;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      wval, rval, sts_w;
  logic [7:0]       mem [BUF_BYTES];

  always_comb begin
    case (tx_addr)
      ADDR_W'('h000): sel_d = SEL_ACC;
      ADDR_W'('h018): sel_d = SEL_STS;
      ADDR_W'('h024): sel_d = SEL_FIFO;
      ADDR_W'('h014): sel_d = SEL_CAP;
      ADDR_W'('hF00): sel_d = SEL_DID;
      ADDR_W'('hF04): sel_d = SEL_RID;
      default:        sel_d = SEL_NONE;
    endcase
  end

  assign sts_w = {4'b0, 2'b01, 2'b00, 16'(BUF_BYTES), 1'b1, cr, 1'b0, da, expct, 3'b000};

  always_comb begin
    case (sel)
      SEL_ACC: rval = {24'b0, 1'b1, 1'b0, active, 5'b0};
      SEL_STS: rval = sts_w;
      SEL_CAP: rval = 32'h3000_0615;
      SEL_DID: rval = {DEV_ID, VEN_ID};
      SEL_RID: rval = REV_ID;
      default: rval = 32'h0;
    endcase
  end

  wire              readable   = (sel != SEL_NONE) && (sel != SEL_FIFO);
  wire              data_cyc   = in_tx & ~tx_start & (tx_w ? tx_wvld : tx_rreq);
  wire              wbyte      = data_cyc & tx_w;
  wire              rbyte      = data_cyc & ~tx_w;
  wire              commit     = in_tx & ~tx_start & ~data_cyc & tx_end;
  wire [POS_W-1:0]  wpos       = POS_W'(wr_idx) + POS_W'(cnt);
  wire              fifo_store = wbyte && sel == SEL_FIFO && fifo_ok && wpos < POS_W'(BUF_BYTES);
  wire              fifo_give  = rbyte && sel == SEL_FIFO && rd_idx < wr_idx;
  wire [31:0]       hdr_len    = {mem[2], mem[3], mem[4], mem[5]};
  wire              exp_new    = (wpos < POS_W'(6)) || (32'(wpos) < hdr_len);
  wire              rsp_ok     = rsp_vld && st == S_EXEC && rsp_len != '0 &&
                                 rsp_len <= LEN_W'(BUF_BYTES) && !commit;

  always_ff @(posedge clk) begin
    if (rsp_ok) begin
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= rsp_data[8*i +: 8];
    end else if (fifo_store) begin
      mem[wpos[AW-1:0]] <= tx_wdata;
    end
  end

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_cmd
    assign cmd_data[8*g +: 8] = mem[g];
  end
  assign cmd_len = wr_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  sel <= SEL_NONE;
      wr_idx <= '0;  rd_idx <= '0;
      cr <= 1'b0;  da <= 1'b0;  expct <= 1'b0;  active <= 1'b0;
      in_tx <= 1'b0;  tx_w <= 1'b0;  fifo_ok <= 1'b0;
      cnt <= '0;  wval <= '0;
      rd_data <= '0;  rd_vld <= 1'b0;  exec_req <= 1'b0;
    end else begin
      exec_req <= 1'b0;
      rd_vld   <= 1'b0;
      rd_data  <= '0;
      if (tx_start) begin
        in_tx   <= 1'b1;
        sel     <= sel_d;
        tx_w    <= tx_write;
        cnt     <= '0;
        wval    <= '0;
        fifo_ok <= (st == S_RECV) || (st == S_READY && wr_idx == '0);
      end else if (wbyte) begin
        if (~&cnt) cnt <= cnt + CNT_W'(1);
        if (cnt < CNT_W'(4)) wval[{cnt[1:0], 3'b000} +: 8] <= tx_wdata;
      end else if (rbyte) begin
        if (~&cnt) cnt <= cnt + CNT_W'(1);
        if (fifo_give) begin
          rd_data <= mem[rd_idx[AW-1:0]];
          rd_vld  <= 1'b1;
          rd_idx  <= rd_idx + IDX_W'(1);
        end else if (readable && cnt < CNT_W'(4)) begin
          rd_data <= rval[{cnt[1:0], 3'b000} +: 8];
          rd_vld  <= 1'b1;
        end
      end else if (commit) begin
        in_tx <= 1'b0;
        if (tx_w) begin
          case (sel)
            SEL_ACC: begin
              if (wval[7:0] == 8'h02) active <= 1'b1;
              if (wval[7:0] == 8'h20) begin
                active <= 1'b0;
                st <= S_IDLE;  wr_idx <= '0;  rd_idx <= '0;
              end
            end
            SEL_STS: begin
              if (wval == 32'h40) begin
                if (st == S_IDLE || st == S_READY) begin
                  st <= S_READY;  cr <= 1'b1;
                end else begin
                  st <= S_IDLE;  cr <= 1'b0;  wr_idx <= '0;  rd_idx <= '0;
                end
              end
              if (wval == 32'h20 && st == S_RECV && !expct) begin
                st <= S_EXEC;  exec_req <= 1'b1;
              end
              if (wval == 32'h02 && st == S_DONE) rd_idx <= '0;
            end
            SEL_FIFO: begin
              if (fifo_ok) begin
                if (wpos > POS_W'(BUF_BYTES)) begin
                  wr_idx <= '0;  st <= S_READY;
                end else begin
                  wr_idx <= wpos[IDX_W-1:0];  st <= S_RECV;  expct <= exp_new;
                end
              end
            end
            default: ;
          endcase
        end else if (sel == SEL_FIFO && rd_idx == wr_idx) begin
          da <= 1'b0;  cr <= 1'b0;
        end
      end
      if (rsp_ok) begin
        rd_idx <= '0;
        wr_idx <= rsp_len[IDX_W-1:0];
        da     <= 1'b1;
        st     <= S_DONE;
      end
    end
  end

  assert_go_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req |=> !exec_req);
  assert_go_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req |-> (st == S_EXEC && $past(st) == S_RECV));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx <= IDX_W'(BUF_BYTES));
  assert_idle_empty_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) != S_IDLE) |-> (wr_idx == '0 && rd_idx == '0));
  assert_rsp_avail_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && $past(st) == S_EXEC) |-> da);
endmodule

// File: tb/sim_tpm_fifo_regs.sv
module sim_tpm_fifo_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 64;
  localparam int M_IDLE = 0, M_READY = 1, M_RECV = 2, M_EXEC = 3, M_DONE = 4;

  logic           clk = 1'b0, rst_n = 1'b0;
  logic           tx_start = 0, tx_write = 0, tx_wvld = 0, tx_rreq = 0, tx_end = 0;
  logic [23:0]    tx_addr = '0;
  logic [7:0]     tx_wdata = '0;
  logic [7:0]     rd_data;
  logic           rd_vld, exec_req;
  logic [6:0]     cmd_len;
  logic [NB*8-1:0] cmd_data;
  logic           rsp_vld = 0;
  logic [7:0]     rsp_len = '0;
  logic [NB*8-1:0] rsp_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tpm_fifo_regs u0 (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_addr(tx_addr), .tx_write(tx_write),
    .tx_wvld(tx_wvld), .tx_wdata(tx_wdata), .tx_rreq(tx_rreq), .tx_end(tx_end),
    .rd_data(rd_data), .rd_vld(rd_vld), .exec_req(exec_req), .cmd_len(cmd_len),
    .cmd_data(cmd_data), .rsp_vld(rsp_vld), .rsp_len(rsp_len), .rsp_data(rsp_data)
  );

  int vectors = 0, miscompares = 0, ex_cnt = 0;

  int ms, mwr, mrd, maddr, mcnt;
  bit mcr, mda, mexp, mact, mtin, mtw, mfok, m_rv, m_ex;
  byte unsigned m_rb;
  byte unsigned mbuf [NB];
  byte unsigned mq [$];

  task automatic chk(input string req, input string what, input longint unsigned got,
                     input longint unsigned exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic void m_idle();
    ms = M_IDLE; mrd = 0; mwr = 0;
  endfunction

  function automatic longint unsigned m_reg(input int a);
    case (a)
      'h000:   return 64'h80 | (64'(mact) << 5);
      'h018:   return 64'h0400_4080 | (64'(mcr) << 6) | (64'(mda) << 4) | (64'(mexp) << 3);
      'h014:   return 64'h3000_0615;
      'hF00:   return 64'h0A11_1F3C;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_readable(input int a);
    return a == 'h000 || a == 'h018 || a == 'h014 || a == 'hF00 || a == 'hF04;
  endfunction

  function automatic void m_commit();
    logic [31:0] v = '0;
    logic [31:0] len;
    for (int i = 0; i < mq.size() && i < 4; i++) v[8*i +: 8] = mq[i];
    if (!mtw) begin
      if (maddr == 'h24 && mrd == mwr) begin mda = 0; mcr = 0; end
      return;
    end
    if (maddr == 'h000) begin
      if (v[7:0] == 8'h02) mact = 1;
      if (v[7:0] == 8'h20) begin mact = 0; m_idle(); end
    end else if (maddr == 'h018) begin
      if (v == 32'h40) begin
        if (ms == M_IDLE || ms == M_READY) begin ms = M_READY; mcr = 1; end
        else begin m_idle(); mcr = 0; end
      end
      if (v == 32'h20 && ms == M_RECV && !mexp) begin ms = M_EXEC; m_ex = 1; end
      if (v == 32'h02 && ms == M_DONE) mrd = 0;
    end else if (maddr == 'h024 && mfok) begin
      if (mwr + mq.size() > NB) begin mwr = 0; ms = M_READY; end
      else begin
        foreach (mq[i]) mbuf[mwr + i] = mq[i];
        mwr += mq.size();
        ms = M_RECV;
        len = {mbuf[2], mbuf[3], mbuf[4], mbuf[5]};
        mexp = (mwr < 6) || (longint'(mwr) < longint'(len));
      end
    end
  endfunction

  function automatic void model_edge();
    bit did = 0;
    m_ex = 0; m_rv = 0; m_rb = 0;
    if (tx_start) begin
      mtin = 1; maddr = int'(tx_addr); mtw = tx_write; mcnt = 0; mq.delete();
      mfok = (ms == M_RECV) || (ms == M_READY && mwr == 0);
    end else if (mtin && mtw && tx_wvld) begin
      mq.push_back(tx_wdata);
    end else if (mtin && !mtw && tx_rreq) begin
      if (maddr == 'h24) begin
        if (mrd < mwr) begin m_rb = mbuf[mrd]; m_rv = 1; mrd++; end
      end else if (m_readable(maddr) && mcnt < 4) begin
        m_rb = 8'(m_reg(maddr) >> (8*mcnt)); m_rv = 1;
      end
      mcnt++;
    end else if (mtin && tx_end) begin
      mtin = 0; did = 1; m_commit();
    end
    if (!did && rsp_vld && ms == M_EXEC && rsp_len >= 1 && rsp_len <= NB) begin
      for (int i = 0; i < int'(rsp_len); i++) mbuf[i] = rsp_data[8*i +: 8];
      mrd = 0; mwr = int'(rsp_len); mda = 1; ms = M_DONE;
    end
  endfunction

  task automatic tick();
    model_edge();
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R10", "rd_vld", rd_vld, m_rv);
    if (m_rv) chk("R2/R10", "rd_data", rd_data, m_rb);
    chk("R6", "exec_req", exec_req, m_ex);
    chk("R9", "cmd_len", cmd_len, mwr);
    if (exec_req) ex_cnt++;
  endtask

  task automatic wr(input int a, input byte unsigned d[$]);
    tx_start = 1; tx_addr = 24'(a); tx_write = 1; tick(); tx_start = 0;
    foreach (d[i]) begin tx_wvld = 1; tx_wdata = d[i]; tick(); tx_wvld = 0; end
    tx_end = 1; tick(); tx_end = 0;
  endtask

  task automatic rd(input int a, input int n, output longint unsigned val, output int nv);
    val = 0; nv = 0;
    tx_start = 1; tx_addr = 24'(a); tx_write = 0; tick(); tx_start = 0;
    for (int k = 0; k < n; k++) begin
      tx_rreq = 1; tick(); tx_rreq = 0;
      if (rd_vld) begin val |= longint'(rd_data) << (8*nv); nv++; end
    end
    tx_end = 1; tick(); tx_end = 0;
  endtask

  task automatic sts_is(input string req, input longint unsigned exp);
    longint unsigned v; int n;
    rd('h018, 4, v, n);
    chk(req, "status", v, exp);
  endtask

  task automatic respond(input int len, input byte unsigned d[$]);
    rsp_data = '0;
    foreach (d[i]) rsp_data[8*i +: 8] = d[i];
    rsp_vld = 1; rsp_len = 8'(len); tick(); rsp_vld = 0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    miscompares++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    longint unsigned v;
    int n, e0;
    byte unsigned q[$];
    ms = M_IDLE; mwr = 0; mrd = 0; mcr = 0; mda = 0; mexp = 0; mact = 0;
    mtin = 0; mtw = 0; mfok = 0; maddr = 0; mcnt = 0; m_rv = 0; m_ex = 0; m_rb = 0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4) rst_n = 1;
    tick();

    sts_is("R1", 64'h0400_4080);
    rd('h000, 1, v, n); chk("R1", "access", v, 64'h80);
    rd('h024, 2, v, n); chk("R1", "empty fifo bytes", n, 0);

    rd('h014, 4, v, n); chk("R2", "capability", v, 64'h3000_0615);
    rd('hF00, 4, v, n); chk("R2", "ids", v, 64'h0A11_1F3C);
    rd('hF04, 4, v, n); chk("R2", "revision", v, 0); chk("R2", "revision bytes", n, 4);
    rd('h018, 6, v, n); chk("R2", "status bytes capped", n, 4);
    rd('h100, 4, v, n); chk("R2", "unmapped bytes", n, 0); chk("R2", "unmapped data", v, 0);

    wr('h000, '{8'h02}); rd('h000, 1, v, n); chk("R5", "access after request", v, 64'hA0);
    wr('h000, '{8'h22}); rd('h000, 1, v, n); chk("R3", "access two bits", v, 64'hA0);
    wr('h018, '{8'h60, 8'h00, 8'h00, 8'h00}); sts_is("R3", 64'h0400_4080);
    wr('h018, '{8'h40, 8'h00, 8'h00, 8'h01}); sts_is("R3", 64'h0400_4080);

    wr('h024, '{8'h01, 8'h02, 8'h03, 8'h04}); chk("R7", "idle fifo write", cmd_len, 0);
    wr('h018, '{8'h40}); sts_is("R4", 64'h0400_40C0);
    wr('h018, '{8'h40}); sts_is("R4", 64'h0400_40C0);

    wr('h024, '{8'h80, 8'h01, 8'h00, 8'h00});
    chk("R9", "len after 4", cmd_len, 4); sts_is("R9", 64'h0400_40C8);
    e0 = ex_cnt; wr('h018, '{8'h20}); repeat (3) tick();
    chk("R6", "go with expect", ex_cnt - e0, 0);
    wr('h024, '{8'h00, 8'h0A, 8'h11, 8'h22, 8'h33, 8'h44});
    chk("R9", "len after 10", cmd_len, 10); sts_is("R9", 64'h0400_40C0);
    chk("R7", "command bytes", cmd_data[63:0], 64'h2211_0A00_0000_0180);
    e0 = ex_cnt; wr('h018, '{8'h20}); repeat (3) tick();
    chk("R6", "go accepted", ex_cnt - e0, 1);
    wr('h024, '{8'h55}); chk("R7", "exec fifo write", cmd_len, 10);
    e0 = ex_cnt; wr('h018, '{8'h20}); repeat (2) tick();
    chk("R6", "go in exec", ex_cnt - e0, 0);

    respond(0, '{});  sts_is("R11", 64'h0400_40C0);
    respond(65, '{}); sts_is("R11", 64'h0400_40C0);
    respond(5, '{8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE});
    sts_is("R11", 64'h0400_40D0); chk("R11", "rsp len", cmd_len, 5);

    rd('h024, 3, v, n); chk("R10", "first part", v, 64'hCCBBAA); chk("R10", "first count", n, 3);
    sts_is("R10", 64'h0400_40D0);
    rd('h024, 4, v, n); chk("R10", "tail", v, 64'hEEDD); chk("R10", "tail count", n, 2);
    sts_is("R10", 64'h0400_4080);
    wr('h018, '{8'h02});
    rd('h024, 5, v, n); chk("R12", "reread", v, 64'hEE_DDCC_BBAA); chk("R12", "reread count", n, 5);
    wr('h018, '{8'h00, 8'h00, 8'h00, 8'h01}); sts_is("R12", 64'h0400_4080);
    chk("R12", "cancel keeps len", cmd_len, 5);

    wr('h018, '{8'h40}); chk("R13", "len after idle", cmd_len, 0);
    rd('h024, 2, v, n); chk("R13", "idle fifo read", n, 0);

    wr('h018, '{8'h40}); sts_is("R4", 64'h0400_40C0);
    q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h28};
    for (int i = 6; i < 40; i++) q.push_back(8'(i));
    wr('h024, q); chk("R8", "len 40", cmd_len, 40);
    q.delete();
    for (int i = 0; i < 30; i++) q.push_back(8'(i + 100));
    wr('h024, q); chk("R8", "overflow index", cmd_len, 0);
    sts_is("R8", 64'h0400_40C0);
    wr('h024, '{8'h07, 8'h07, 8'h00, 8'h00, 8'h00, 8'h06});
    chk("R8", "accepted after overflow", cmd_len, 6);
    e0 = ex_cnt; wr('h018, '{8'h20}); repeat (2) tick();
    chk("R6", "go after overflow", ex_cnt - e0, 1);
    wr('h000, '{8'h20}); rd('h000, 1, v, n); chk("R5", "release locality", v, 64'h80);
    chk("R13", "len after release", cmd_len, 0);
    e0 = ex_cnt; wr('h018, '{8'h20}); repeat (2) tick();
    chk("R6", "go in idle", ex_cnt - e0, 0);

    wr('h018, '{8'h40});
    wr('h024, '{8'h01, 8'h02, 8'h03}); sts_is("R9", 64'h0400_40C8);
    wr('h018, '{8'h40}); sts_is("R4", 64'h0400_4088); chk("R4", "len after abort", cmd_len, 0);

    wr('h018, '{8'h40});
    wr('h024, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0C, 8'h01, 8'h02});
    chk("R9", "partial len", cmd_len, 8); sts_is("R9", 64'h0400_40C8);
    e0 = ex_cnt; wr('h018, '{8'h20}); repeat (2) tick();
    chk("R6", "go before complete", ex_cnt - e0, 0);
    wr('h024, '{8'h03, 8'h04, 8'h05, 8'h06});
    chk("R9", "full len", cmd_len, 12); sts_is("R9", 64'h0400_40C0);

    repeat (3) tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule